// File: doc/BRIEF.md
# Low-Memory Register Overlay Decoder

This block sits between a processor's load/store port and external word memory. It decodes each word address so that selected slots among the lowest thirty-two addresses are served by a local bank of special registers, while every other address goes to external memory unchanged. The local bank applies a fixed rule to each slot:

- Slot 0 is a hard zero.
- Slot 12 is a mask word. Its upper and lower bit groups are fixed, and only a middle field can be written.
- Slot 5 holds a channel number. Only a separate I/O-side strobe can load it.
- Slot 7 packs two count fields.
- Slots 16 to 31 are sixteen full-width index registers.

Bits are numbered with bit 0 as the most significant bit of the 64-bit word. In this document, "vector [h:l]" gives the matching little-endian range.

The processor side is a valid/ready request stream, and reads come back on a response strobe. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The response has no back-pressure, so the requester must always accept `resp_valid`.

Requests bound for external memory stall while `mem_ready` is low. Only one external read may be in flight. While it is outstanding, `req_ready` stays low for every address, and this keeps responses in order.

Top module: `lowmem_overlay`

## Requirements
- R1: Requests to local slots (0, 1, 3, 5 to 12, and 16 to 31) never raise `mem_valid`. A local read accepted at one edge returns `resp_valid` with data in the very next cycle.
- R2: Addresses 2, 4, 13, 14 and 15, and every address of 32 or more, are forwarded with address, write flag and write data unchanged. External read data is returned on `resp_rdata` when `mem_rvalid` is high.
- R3: Slot 0 reads as 64 zero bits, and writes to it change nothing.
- R4: Slot 12 always reads ones in bits 0..19 (vector [63:44]) and zeros in bits 48..63 (vector [15:0]). Bits 20..47 (vector [43:16]) hold the last written value and reset to zero.
- R5: Slot 5 returns the 7-bit channel number in bits 12..18 (vector [51:45]) and zeros elsewhere. The value loads from `chan_value` on a cycle with `chan_load` high, and processor writes to slot 5 have no effect.
- R6: Slot 7 stores a leading-zero count in bits 17..23 (vector [46:40]) and an all-ones count in bits 44..50 (vector [19:13]), both writable. All other bits read zero.
- R7: Slots 16 to 31 are sixteen independent 64-bit registers that read back exactly what was last written and reset to zero.
- R8: Slots 1, 3, 6, 8, 9, 10 and 11 belong to functions outside this block. They read zero and ignore writes.
- R9: While an external read is outstanding, `req_ready` is low for every address. A request to external memory waits while `mem_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 64 | Write data |
| resp_valid | output | 1 | Read data valid (no back-pressure) |
| resp_rdata | output | 64 | Read data |
| mem_valid | output | 1 | External memory request |
| mem_ready | input | 1 | External memory accepts request |
| mem_write | output | 1 | External write flag |
| mem_addr | output | AW | External word address |
| mem_wdata | output | 64 | External write data |
| mem_rvalid | input | 1 | External read data valid |
| mem_rdata | input | 64 | External read data |
| chan_load | input | 1 | I/O-side strobe that loads the channel number |
| chan_value | input | 7 | Channel number to load |

## Verification
The hardest case to reach is a local-slot request arriving while an external read is still in flight. The processor can only create it by following a slow external read with an immediate request to a register slot.

The bench's memory model answers reads two cycles late and drops `mem_ready` on every third cycle. The bench then switches the pending request to slot 7 right after the external read is accepted. It checks that `req_ready` stays low and that the external data still comes back intact.

Full sweeps of all thirty-two low addresses with an all-ones and a mixed pattern exercise every fixed-bit, writable-bit and ignored-write rule.

// File: rtl/lowmem_pkg.sv
package lowmem_pkg;
  localparam int WORD_W = 64;
  localparam int CHAN_W = 7;
  localparam int CNT_W  = 7;

  // Slot numbers within the low window that carry special rules
  localparam int S_ZERO = 0;
  localparam int S_CHAN = 5;
  localparam int S_CNT  = 7;
  localparam int S_MASK = 12;

  // Fields given in MSB-0 numbering, converted to vector indices
  localparam int CHAN_HI = WORD_W - 1 - 12;
  localparam int CHAN_LO = WORD_W - 1 - 18;
  localparam int LZC_HI  = WORD_W - 1 - 17;
  localparam int LZC_LO  = WORD_W - 1 - 23;
  localparam int AOC_HI  = WORD_W - 1 - 44;
  localparam int AOC_LO  = WORD_W - 1 - 50;
  localparam int MONE_LO = WORD_W - 1 - 19;
  localparam int MWR_HI  = WORD_W - 1 - 20;
  localparam int MWR_LO  = WORD_W - 1 - 47;
  localparam int MWR_W   = MWR_HI - MWR_LO + 1;

  typedef enum logic [2:0] {
    SLOT_MEM,
    SLOT_ZERO,
    SLOT_RSVD,
    SLOT_CHAN,
    SLOT_CNT,
    SLOT_MASK,
    SLOT_IDX
  } slot_e;
endpackage

// File: rtl/lowmem_decode.sv
module lowmem_decode
  import lowmem_pkg::*;
#(
  parameter int AW   = 18,
  parameter int NIDX = 16
) (
  input  logic [AW-1:0]           addr,
  output slot_e                   kind,
  output logic [$clog2(NIDX)-1:0] idx
);
  localparam int IW  = $clog2(NIDX);
  localparam int WIN = 2 * NIDX;

  always_comb begin
    idx = addr[IW-1:0];
    if (addr >= AW'(WIN)) begin
      kind = SLOT_MEM;
    end else if (addr >= AW'(NIDX)) begin
      kind = SLOT_IDX;
    end else begin
      case (int'(addr[IW-1:0]))
        S_ZERO:             kind = SLOT_ZERO;
        S_CHAN:             kind = SLOT_CHAN;
        S_CNT:              kind = SLOT_CNT;
        S_MASK:             kind = SLOT_MASK;
        2, 4, 13, 14, 15:   kind = SLOT_MEM;
        default:            kind = SLOT_RSVD;
      endcase
    end
  end
endmodule

// File: rtl/lowmem_regs.sv
module lowmem_regs
  import lowmem_pkg::*;
#(
  parameter int NIDX = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  slot_e                   kind,
  input  logic [$clog2(NIDX)-1:0] idx,
  input  logic [WORD_W-1:0]       wdata,
  input  logic                    chan_load,
  input  logic [CHAN_W-1:0]       chan_value,
  output logic [WORD_W-1:0]       rdata
);
  logic [CHAN_W-1:0] chan_q;
  logic [CNT_W-1:0]  lzc_q, aoc_q;
  logic [MWR_W-1:0]  mask_q;
  logic [WORD_W-1:0] idx_q [NIDX];

  always_ff @(posedge clk) begin
    if (!rst_n)         chan_q <= '0;
    else if (chan_load) chan_q <= chan_value;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lzc_q <= '0;
      aoc_q <= '0;
    end else if (wr_en && kind == SLOT_CNT) begin
      lzc_q <= wdata[LZC_HI:LZC_LO];
      aoc_q <= wdata[AOC_HI:AOC_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          mask_q <= '0;
    else if (wr_en && kind == SLOT_MASK) mask_q <= wdata[MWR_HI:MWR_LO];
  end

  for (genvar g = 0; g < NIDX; g++) begin : g_idx
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                              q <= '0;
      else if (wr_en && kind == SLOT_IDX && int'(idx) == g)    q <= wdata;
    end
    assign idx_q[g] = q;
  end

  always_comb begin
    rdata = '0;
    case (kind)
      SLOT_CHAN: rdata[CHAN_HI:CHAN_LO] = chan_q;
      SLOT_CNT: begin
        rdata[LZC_HI:LZC_LO] = lzc_q;
        rdata[AOC_HI:AOC_LO] = aoc_q;
      end
      SLOT_MASK: begin
        rdata[WORD_W-1:MONE_LO] = '1;
        rdata[MWR_HI:MWR_LO]    = mask_q;
      end
      SLOT_IDX:  rdata = idx_q[idx];
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/lowmem_overlay.sv
module lowmem_overlay
  import lowmem_pkg::*;
#(
  parameter int AW   = 18,
  parameter int NIDX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [63:0]       req_wdata,
  output logic              resp_valid,
  output logic [63:0]       resp_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [AW-1:0]     mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  input  logic              chan_load,
  input  logic [6:0]        chan_value
);
  localparam int IW = $clog2(NIDX);

  slot_e             kind;
  logic [IW-1:0]     idx;
  logic              local_hit, accept;
  logic              pend_q, rsp_q;
  logic [63:0]       reg_rd, rsp_data_q;

  lowmem_decode #(.AW(AW), .NIDX(NIDX)) u_dec (
    .addr (req_addr),
    .kind (kind),
    .idx  (idx)
  );

  assign local_hit = (kind != SLOT_MEM);
  assign req_ready = !pend_q && (local_hit || mem_ready);
  assign accept    = req_valid && req_ready;

  assign mem_valid = req_valid && !local_hit && !pend_q;
  assign mem_write = req_write;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;

  lowmem_regs #(.NIDX(NIDX)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (accept && req_write && local_hit),
    .kind       (kind),
    .idx        (idx),
    .wdata      (req_wdata),
    .chan_load  (chan_load),
    .chan_value (chan_value),
    .rdata      (reg_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      rsp_q      <= 1'b0;
      rsp_data_q <= '0;
    end else begin
      rsp_q <= accept && !req_write && local_hit;
      if (accept && !req_write && local_hit) rsp_data_q <= reg_rd;
      if (accept && !req_write && !local_hit) pend_q <= 1'b1;
      else if (mem_rvalid)                    pend_q <= 1'b0;
    end
  end

  assign resp_valid = rsp_q || mem_rvalid;
  assign resp_rdata = rsp_q ? rsp_data_q : mem_rdata;
endmodule

// File: rtl/lowmem_overlay_chk.sv
module lowmem_overlay_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [63:0]   req_wdata,
  input logic          resp_valid,
  input logic [63:0]   resp_rdata,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [63:0]   mem_wdata
);
  logic is_local, rd_acc;
  always_comb begin
    is_local = (req_addr < AW'(32)) &&
               !(req_addr == AW'(2) || req_addr == AW'(4) || req_addr == AW'(13) ||
                 req_addr == AW'(14) || req_addr == AW'(15));
    rd_acc = req_valid && req_ready && !req_write;
  end

  // R1
  local_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && is_local |-> !mem_valid);

  // R1
  local_rsp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && is_local |=> resp_valid);

  // R2
  forward_intact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr == req_addr && mem_write == req_write && mem_wdata == req_wdata);

  // R3
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && req_addr == AW'(0) |=> resp_rdata == 64'd0);

  // R4
  mask_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && req_addr == AW'(12) |=> resp_rdata[63:44] == 20'hFFFFF && resp_rdata[15:0] == 16'h0);

  // R9
  mem_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |-> !req_ready);
endmodule

bind lowmem_overlay lowmem_overlay_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .resp_valid (resp_valid),
  .resp_rdata (resp_rdata),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_write  (mem_write),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata)
);

// File: tb/lowmem_overlay_bench.sv
module lowmem_overlay_bench;
  localparam int AW = 18;

  localparam logic [63:0] M_ONES = 64'hFFFF_F000_0000_0000;
  localparam logic [63:0] M_WR   = 64'h0000_0FFF_FFFF_0000;
  localparam logic [63:0] M_CNT  = 64'h0000_7F00_000F_E000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, resp_valid, mem_valid, mem_write;
  logic [63:0] resp_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic chan_load = 1'b0;
  logic [6:0] chan_value = '0;

  int n_chk = 0, n_bad = 0, leak = 0, cyc = 0;
  logic [63:0] shadow [32];
  logic [6:0]  chan_exp = '0;
  logic [AW-1:0] wr_a = '0, rd_a = '0;
  logic [63:0] wr_d = '0;
  int rd_cnt = 0;

  always #5 clk = ~clk;

  lowmem_overlay #(.AW(AW), .NIDX(16)) u_lowmem_overlay (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .chan_load(chan_load), .chan_value(chan_value)
  );

  function automatic logic [63:0] ext_val(logic [AW-1:0] a);
    return 64'hC0DE_0000_0000_0000 | {46'd0, a};
  endfunction

  function automatic bit is_fwd(int a);
    return a >= 32 || a == 2 || a == 4 || a == 13 || a == 14 || a == 15;
  endfunction

  function automatic string tag_of(int a);
    if (is_fwd(a)) return "R2";
    if (a == 0)    return "R3";
    if (a == 12)   return "R4";
    if (a == 5)    return "R5";
    if (a == 7)    return "R6";
    if (a >= 16)   return "R7";
    return "R8";
  endfunction

  function automatic logic [63:0] exp_read(int a);
    if (is_fwd(a)) return ext_val(AW'(a));
    if (a == 5)    return {12'd0, chan_exp, 45'd0};
    if (a == 7 || a == 12 || a >= 16) return shadow[a];
    return 64'd0;
  endfunction

  // External memory model: stalls every third cycle, answers reads two cycles late
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= (cyc % 3) != 0;
    if (mem_valid && mem_ready && mem_write) begin
      wr_a <= mem_addr;
      wr_d <= mem_wdata;
    end
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready && !mem_write) begin
      rd_cnt <= 2;
      rd_a   <= mem_addr;
    end else if (rd_cnt != 0) begin
      rd_cnt <= rd_cnt - 1;
      if (rd_cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= ext_val(rd_a);
      end
    end
  end

  // R1: local-slot request must never leak to memory
  always @(negedge clk) begin
    if (rst_n && req_valid && !is_fwd(int'(req_addr)) && mem_valid) leak++;
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [AW-1:0] a, input logic [63:0] d,
                      output logic [63:0] r, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    r = '0; lat = 0;
    if (!w) begin
      @(negedge clk);
      while (!resp_valid) begin @(negedge clk); lat++; end
      r = resp_rdata;
    end
  endtask

  task automatic wr(int a, logic [63:0] d);
    logic [63:0] r; int lat;
    xfer(1'b1, AW'(a), d, r, lat);
    if (is_fwd(a)) begin
      chk("R2 wr addr", {46'd0, wr_a}, {46'd0, AW'(a)});
      chk("R2 wr data", wr_d, d);
    end else if (a == 7) shadow[a] = d & M_CNT;
    else if (a == 12)    shadow[a] = (d & M_WR) | M_ONES;
    else if (a >= 16)    shadow[a] = d;
  endtask

  task automatic rd(int a);
    logic [63:0] r; int lat;
    xfer(1'b0, AW'(a), 64'd0, r, lat);
    chk(tag_of(a), r, exp_read(a));
    if (!is_fwd(a)) chk("R1 latency", 64'(lat), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) shadow[i] = 64'd0;
    shadow[12] = M_ONES;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset resp_valid", {63'd0, resp_valid}, 64'd0);
    chk("R2 reset mem_valid", {63'd0, mem_valid}, 64'd0);

    // Reset state of the whole window
    for (int a = 0; a < 32; a++) rd(a);

    // Sweep 1: all ones
    for (int a = 0; a < 32; a++) wr(a, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int a = 0; a < 32; a++) rd(a);

    // Sweep 2: mixed pattern unique per address
    for (int a = 0; a < 32; a++) wr(a, 64'h5A5A_3C3C_9696_0F0F ^ (64'(a) * 64'h0001_0203_0405_0607));
    for (int a = 0; a < 32; a++) rd(a);

    // R5: I/O-side load, then processor write must not disturb it
    @(negedge clk); chan_load = 1'b1; chan_value = 7'h55;
    @(negedge clk); chan_load = 1'b0; chan_exp = 7'h55;
    rd(5);
    wr(5, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(5);
    @(negedge clk); chan_load = 1'b1; chan_value = 7'h2A;
    @(negedge clk); chan_load = 1'b0; chan_exp = 7'h2A;
    rd(5);

    // R3 and R8 after zero write pattern too
    wr(0, 64'h1234_5678_9ABC_DEF0); rd(0);
    wr(9, 64'h1234_5678_9ABC_DEF0); rd(9);

    // R2: addresses above the window
    wr(32, 64'hDEAD_BEEF_0000_0001); rd(32);
    wr(1000, 64'h0BAD_F00D_0000_0002); rd(1000);
    wr((1 << AW) - 1, 64'h8000_0000_0000_0003); rd((1 << AW) - 1);

    // R9: local request while an external read is outstanding
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(40);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_addr = AW'(7);
    @(negedge clk);
    chk("R9 ready low while pending", {63'd0, req_ready}, 64'd0);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    chk("R9 pending data", resp_rdata, ext_val(AW'(40)));
    rd(7);

    chk("R1 no memory leak", 64'(leak), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule